// File: doc/BRIEF.md
# Synthesizer Control Serial Slave

This block is the serial control front end of a PLL frequency synthesizer. It acts as an I2C slave. It holds every programmable field the synthesizer needs: the main divide ratio, the reference divide ratio, the output port latches, the charge-pump current code, the divide-by-two prescaler enable, the clock-output source select and a test-mode code. A master writes these fields as one group of four data bytes after the address byte. A read returns a single status byte. That byte combines a sticky power-on flag with the live lock indication, the levels of the three input-capable port pins and the ADC level code.

The two bus lines are sampled with the system clock, and START and STOP are recognised from SDA edges while SCL is high. A 2-bit strap picks one of four slave addresses, so several synthesizers can share one bus. The four data bytes are first collected in a staging register. The outputs change together, in one cycle, only after the fourth byte has been acknowledged, so the divider never sees a partly written ratio.

Top module: `synth_ctrl_i2c`

## Requirements
- R1: The slave address is the 7-bit value {ADDR_BASE (default 5'b11000), addr_sel_i[1:0]}. The address byte is that value followed by the R/W bit (0 = write, 1 = read). A matching address is acknowledged by pulling SDA low in the ninth clock.
- R2: An address byte that does not match is not acknowledged. The slave then ignores the bus until the next START, and no data byte changes any output.
- R3: The four write bytes form a 32-bit word D, first byte in D[31:24]. The fields are main_div_o=D[31:15], ref_div_o=D[14:11], cp_cur_o=D[10:9], presc_en_o=D[8], clk_sel_o=D[7], test_mode_o=D[6:4] and port_o=D[3:0]. Each of the four bytes is acknowledged.
- R4: The configuration outputs change only at the end of the acknowledge of the fourth data byte, and all at once. A write that stops after fewer bytes leaves every output unchanged.
- R5: A data byte after the fourth is not acknowledged and does not change the outputs.
- R6: A read returns the status byte {por_flag, lock_i, port_in_i[2:0], adc_code_i[2:0]}, MSB first.
- R7: The power-on flag is 1 after reset. It clears once a status byte has been fully read, including the master's acknowledge slot.
- R8: If the master acknowledges a status byte, the slave sends a fresh status byte. If the master does not acknowledge, the slave releases SDA and goes idle.
- R9: After reset all configuration outputs are 0 and SDA is released.
- R10: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| addr_sel_i | input | 2 | Address strap code |
| lock_i | input | 1 | PLL in-lock indication |
| port_in_i | input | 3 | Levels of input-capable port pins |
| adc_code_i | input | 3 | ADC level code (0 to 4) |
| main_div_o | output | 17 | Main divide ratio |
| ref_div_o | output | 4 | Reference divide ratio code |
| cp_cur_o | output | 2 | Charge-pump current code |
| presc_en_o | output | 1 | Divide-by-two prescaler enable |
| clk_sel_o | output | 1 | Clock output source: 0 crystal, 1 comparison |
| test_mode_o | output | 3 | Test-mode code |
| port_o | output | 4 | Output port latches |

## Verification
The bench tries every address against every strap value. A design that compares the wrong bits would acknowledge a foreign address, or would let that address's data bytes reach the outputs. It aborts writes after three bytes and sends a fifth byte, which shows whether a design updates outputs byte by byte or accepts overflow bytes. It reads twice inside one transfer to confirm the power-on flag is cleared exactly by the first completed read. It sweeps every ADC code against every port pattern, which exposes a status byte with swapped or shifted fields.

// File: rtl/synth_ctrl_pkg.sv
package synth_ctrl_pkg;
  parameter int MAIN_W     = 17;
  parameter int REF_W      = 4;
  parameter int CP_W       = 2;
  parameter int TEST_W     = 3;
  parameter int PORT_W     = 4;
  parameter int DATA_BYTES = 4;
  localparam int CFG_W     = DATA_BYTES * 8;

  // field order is the bit order of the written word, first byte on top
  typedef struct packed {
    logic [MAIN_W-1:0] main_div;
    logic [REF_W-1:0]  ref_div;
    logic [CP_W-1:0]   cp_cur;
    logic              presc_en;
    logic              clk_sel;
    logic [TEST_W-1:0] test_mode;
    logic [PORT_W-1:0] port;
  } cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK_A, ST_WDATA, ST_ACK_W, ST_RDATA, ST_ACK_R
  } st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o && !scl_q;
  assign scl_fall_o = !scl_o && scl_q;
  assign start_o    = scl_o && scl_q && sda_q && !sda_o;
  assign stop_o     = scl_o && scl_q && !sda_q && sda_o;
endmodule

// File: rtl/synth_ctrl_fsm.sv
module synth_ctrl_fsm
  import synth_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [6:0] dev_addr_i,
  input  logic [7:0] status_i,
  output logic       sda_oe_o,
  output logic [7:0] byte_o,
  output logic       byte_we_o,
  output logic       commit_o,
  output logic       read_done_o
);
  localparam int BIDX_W = $clog2(DATA_BYTES + 1);

  st_e              st;
  logic [3:0]       cnt;
  logic [7:0]       sh, tx;
  logic             rw, mack;
  logic [BIDX_W-1:0] bidx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st          <= ST_IDLE;
      cnt         <= '0;
      sh          <= '0;
      tx          <= '0;
      rw          <= 1'b0;
      mack        <= 1'b0;
      bidx        <= '0;
      sda_oe_o    <= 1'b0;
      byte_we_o   <= 1'b0;
      commit_o    <= 1'b0;
      read_done_o <= 1'b0;
    end else begin
      byte_we_o   <= 1'b0;
      commit_o    <= 1'b0;
      read_done_o <= 1'b0;
      if (start_i) begin
        st       <= ST_ADDR;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        st       <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR: begin
            if (scl_rise_i) begin
              sh  <= {sh[6:0], sda_i};
              cnt <= cnt + 4'd1;
            end else if (scl_fall_i && cnt == 4'd8) begin
              cnt <= '0;
              if (sh[7:1] == dev_addr_i) begin
                sda_oe_o <= 1'b1;
                rw       <= sh[0];
                bidx     <= '0;
                st       <= ST_ACK_A;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_ACK_A: if (scl_fall_i) begin
            if (rw) begin
              tx       <= status_i;
              sda_oe_o <= ~status_i[7];
              st       <= ST_RDATA;
            end else begin
              sda_oe_o <= 1'b0;
              st       <= ST_WDATA;
            end
          end
          ST_WDATA: begin
            if (scl_rise_i) begin
              sh  <= {sh[6:0], sda_i};
              cnt <= cnt + 4'd1;
            end else if (scl_fall_i && cnt == 4'd8) begin
              cnt <= '0;
              if (bidx < BIDX_W'(DATA_BYTES)) begin
                sda_oe_o  <= 1'b1;
                byte_we_o <= 1'b1;
                bidx      <= bidx + 1'b1;
                st        <= ST_ACK_W;
              end else begin
                st <= ST_IDLE;  // overflow byte: no ack
              end
            end
          end
          ST_ACK_W: if (scl_fall_i) begin
            sda_oe_o <= 1'b0;
            st       <= ST_WDATA;
            if (bidx == BIDX_W'(DATA_BYTES)) commit_o <= 1'b1;
          end
          ST_RDATA: begin
            if (scl_rise_i) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall_i) begin
              if (cnt == 4'd8) begin
                cnt      <= '0;
                sda_oe_o <= 1'b0;
                st       <= ST_ACK_R;
              end else begin
                tx       <= {tx[6:0], 1'b0};
                sda_oe_o <= ~tx[6];
              end
            end
          end
          ST_ACK_R: begin
            if (scl_rise_i) begin
              mack        <= ~sda_i;
              read_done_o <= 1'b1;
            end else if (scl_fall_i) begin
              if (mack) begin
                tx       <= status_i;
                sda_oe_o <= ~status_i[7];
                st       <= ST_RDATA;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign byte_o = sh;

  assert_oe_scl_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe_o));
  assert_ack_on_match_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_ACK_A && $past(st) == ST_ADDR) |-> $past(sh[7:1] == dev_addr_i));
  assert_commit_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (bidx == BIDX_W'(DATA_BYTES)));
endmodule

// File: rtl/synth_ctrl_regs.sv
module synth_ctrl_regs
  import synth_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] byte_i,
  input  logic       byte_we_i,
  input  logic       commit_i,
  input  logic       read_done_i,
  output cfg_t       cfg_o,
  output logic       por_o
);
  logic [CFG_W-1:0] stage;
  cfg_t             cfg_q;
  logic             por_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage <= '0;
      cfg_q <= '0;
      por_q <= 1'b1;
    end else begin
      if (byte_we_i) stage <= {stage[CFG_W-9:0], byte_i};
      if (commit_i)  cfg_q <= cfg_t'(stage);
      if (read_done_i) por_q <= 1'b0;
    end
  end

  assign cfg_o = cfg_q;
  assign por_o = por_q;

  assert_cfg_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(cfg_q));
  assert_por_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(por_q) |-> $past(read_done_i));
endmodule

// File: rtl/synth_ctrl_i2c.sv
module synth_ctrl_i2c
  import synth_ctrl_pkg::*;
#(
  parameter logic [4:0] ADDR_BASE   = 5'b11000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [1:0]        addr_sel_i,
  input  logic              lock_i,
  input  logic [2:0]        port_in_i,
  input  logic [2:0]        adc_code_i,
  output logic [MAIN_W-1:0] main_div_o,
  output logic [REF_W-1:0]  ref_div_o,
  output logic [CP_W-1:0]   cp_cur_o,
  output logic              presc_en_o,
  output logic              clk_sel_o,
  output logic [TEST_W-1:0] test_mode_o,
  output logic [PORT_W-1:0] port_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic [7:0] wbyte, status;
  logic byte_we, commit, read_done, por;
  cfg_t cfg;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_p), .stop_o(stop_p)
  );

  assign status = {por, lock_i, port_in_i, adc_code_i};

  synth_ctrl_fsm u_fsm (
    .clk_i, .rst_ni, .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start_p), .stop_i(stop_p),
    .dev_addr_i({ADDR_BASE, addr_sel_i}), .status_i(status),
    .sda_oe_o, .byte_o(wbyte), .byte_we_o(byte_we), .commit_o(commit),
    .read_done_o(read_done)
  );

  synth_ctrl_regs u_regs (
    .clk_i, .rst_ni, .byte_i(wbyte), .byte_we_i(byte_we), .commit_i(commit),
    .read_done_i(read_done), .cfg_o(cfg), .por_o(por)
  );

  assign main_div_o  = cfg.main_div;
  assign ref_div_o   = cfg.ref_div;
  assign cp_cur_o    = cfg.cp_cur;
  assign presc_en_o  = cfg.presc_en;
  assign clk_sel_o   = cfg.clk_sel;
  assign test_mode_o = cfg.test_mode;
  assign port_o      = cfg.port;
endmodule

// File: tb/sim_synth_ctrl_i2c.sv
module sim_synth_ctrl_i2c;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic clk = 0, rst_n = 0;
  logic scl = 1, m_sda = 1;
  logic sda_bus, sda_oe;
  logic [1:0] strap = 0;
  logic lock = 0;
  logic [2:0] pin = 0, adc = 0;
  logic [16:0] main_div;
  logic [3:0] ref_div, port;
  logic [1:0] cp_cur;
  logic presc_en, clk_sel;
  logic [2:0] test_mode;
  int n_chk = 0, n_err = 0;
  logic [31:0] exp_cfg = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  synth_ctrl_i2c u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .addr_sel_i(strap), .lock_i(lock), .port_in_i(pin), .adc_code_i(adc),
    .main_div_o(main_div), .ref_div_o(ref_div), .cp_cur_o(cp_cur),
    .presc_en_o(presc_en), .clk_sel_o(clk_sel), .test_mode_o(test_mode), .port_o(port)
  );

  wire [31:0] cfg_act = {main_div, ref_div, cp_cur, presc_en, clk_sel, test_mode, port};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic wq(input int k);
    repeat (k * Q) @(negedge clk);
  endtask

  task automatic i2c_start;
    m_sda = 1; scl = 1; wq(1);
    m_sda = 0; wq(1);
    scl = 0; wq(1);
  endtask

  task automatic i2c_stop;
    m_sda = 0; wq(1);
    scl = 1; wq(1);
    m_sda = 1; wq(1);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wq(1);
    scl = 1; wq(2);
    scl = 0; wq(1);
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1; wq(1);
    scl = 1; wq(1);
    b = sda_bus; wq(1);
    scl = 0; wq(1);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(r);
    ack = ~r;
  endtask

  task automatic read_byte(input logic master_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) recv_bit(d[i]);
    send_bit(~master_ack);
  endtask

  initial begin
    logic ack;
    logic [7:0] rb;
    logic [31:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1;
    wq(1);
    // R9 reset state
    chk("R9 cfg after reset", cfg_act, 32'h0);
    chk("R9 sda released", {31'h0, sda_oe}, 32'h0);

    // R1/R2/R3 address sweep against every strap code
    for (int s = 0; s < 4; s++) begin
      for (int a = 0; a < 4; a++) begin
        strap = 2'(s);
        d = 32'h9E3779B9 * 32'(s * 4 + a + 1);
        i2c_start;
        send_byte({5'b11000, 2'(a), 1'b0}, ack);
        chk("R1 address ack", {31'h0, ack}, {31'h0, a == s});
        for (int k = 0; k < 4; k++) begin
          send_byte(d[31-8*k -: 8], ack);
          if (a == s) chk("R3 data ack", {31'h0, ack}, 32'h1);
          else chk("R2 data after mismatch", {31'h0, ack}, 32'h0);
        end
        i2c_stop;
        if (a == s) exp_cfg = d;
        chk(a == s ? "R3 field map" : "R2 cfg unchanged", cfg_act, exp_cfg);
      end
    end
    chk("R3 main_div", {15'h0, main_div}, {15'h0, exp_cfg[31:15]});
    chk("R3 ref/cp", {26'h0, ref_div, cp_cur}, {26'h0, exp_cfg[14:9]});

    // R2 upper address bits differ
    strap = 0;
    i2c_start;
    send_byte({5'b01000, 2'b00, 1'b0}, ack);
    chk("R2 upper bits mismatch", {31'h0, ack}, 32'h0);
    i2c_stop;

    // R4 partial write keeps old config
    i2c_start;
    send_byte({5'b11000, 2'b00, 1'b0}, ack);
    for (int k = 0; k < 3; k++) send_byte(8'hA5 ^ 8'(k), ack);
    chk("R4 mid-write unchanged", cfg_act, exp_cfg);
    i2c_stop;
    chk("R4 short write unchanged", cfg_act, exp_cfg);

    // R5 fifth byte rejected
    d = 32'h1234_5678;
    i2c_start;
    send_byte({5'b11000, 2'b00, 1'b0}, ack);
    for (int k = 0; k < 4; k++) send_byte(d[31-8*k -: 8], ack);
    send_byte(8'hFF, ack);
    chk("R5 fifth byte nack", {31'h0, ack}, 32'h0);
    i2c_stop;
    exp_cfg = d;
    chk("R5 cfg from first four", cfg_act, exp_cfg);

    // R7/R8 first read with repeat, then nack
    lock = 1; pin = 3'b101; adc = 3'd3;
    i2c_start;
    send_byte({5'b11000, 2'b00, 1'b1}, ack);
    chk("R1 read address ack", {31'h0, ack}, 32'h1);
    read_byte(1'b1, rb);
    chk("R7 por set on first read", {24'h0, rb}, {24'h0, 1'b1, 1'b1, 3'b101, 3'd3});
    read_byte(1'b0, rb);
    chk("R8 repeated byte after ack, R7 por cleared", {24'h0, rb}, {24'h0, 1'b0, 1'b1, 3'b101, 3'd3});
    wq(1);
    chk("R8 released after nack", {31'h0, sda_oe}, 32'h0);
    i2c_stop;

    // R6 status sweep
    for (int ac = 0; ac < 5; ac++) begin
      for (int p = 0; p < 8; p++) begin
        adc = 3'(ac); pin = 3'(p); lock = 1'(p ^ ac);
        i2c_start;
        send_byte({5'b11000, 2'b00, 1'b1}, ack);
        read_byte(1'b0, rb);
        i2c_stop;
        chk("R6 status byte", {24'h0, rb}, {24'h0, 1'b0, 1'(p ^ ac), 3'(p), 3'(ac)});
      end
    end
    chk("R6 cfg untouched by reads", cfg_act, exp_cfg);

    summary;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog act=running exp=done");
    summary;
    $finish;
  end
endmodule